// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that fronts a 256-byte nonvolatile array. The array is held in on-chip registers. The target answers to a 7-bit address made of a fixed 1010 prefix followed by three strap inputs. The array is addressed through an 8-bit word pointer that persists between transfers. A controller can write one byte, or up to four bytes within one aligned 4-byte page. It can read from the current pointer, set the pointer with a dummy write and then read after a repeated START, or stream bytes back for as long as it keeps acknowledging.

Write data is collected in a page buffer and reaches the array only when a STOP arrives. The STOP also starts a self-timed write cycle, which is modelled by a down-counter of `WR_CYCLES` system clocks. While that counter runs, `busy_o` is high and the target refuses its own address. A controller can therefore poll for completion. A sibling port-expander target on the same bus can watch `busy_o` and keep serving its own accesses.

The write-control input `wc_ni` blocks programming while it is high. Bytes are still acknowledged, but the STOP then neither changes the array nor starts a busy cycle. SCL and SDA are oversampled by the system clock. SDA is driven only low, through an open-drain enable.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges a START followed by address byte {1010, strap_i[2:0], rw}, with rw as bit 0: 1 selects a read, 0 selects a write. It leaves SDA released during the ninth clock for any other address.
- R2: In a write transfer, the byte after the address is the word address. Every following byte is data. The target acknowledges each of them.
- R3: A byte write stores its data at the word address once STOP is received. A later read of that location returns the data.
- R4: In a write, each data byte advances only pointer bits [1:0]. A fifth byte wraps to the first slot written and overwrites it, and locations outside the 4-byte page stay unchanged.
- R5: Buffered write data reaches the array only on STOP. A repeated START discards it, so the location keeps its old value and no busy cycle starts.
- R6: A committing STOP raises busy_o on the third clock after the STOP edge on SDA. busy_o then stays high for exactly WR_CYCLES clocks.
- R7: While busy_o is high, the target does not acknowledge its own address.
- R8: While wc_ni is high, address and data bytes are still acknowledged. The STOP leaves the array unchanged and busy_o stays low.
- R9: The word pointer holds one past the last location read or written. A read without a preceding word address returns the byte at that pointer.
- R10: A dummy write of a word address, followed by a repeated START with rw=1, returns the byte at that address.
- R11: During a read, each acknowledge from the controller advances the pointer by one, wrapping from 255 to 0, and the next byte is sent. A not-acknowledge ends the read.
- R12: After reset, busy_o is low, SDA is released and every array location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| strap_i | input | 3 | Low three bits of the target address |
| wc_ni | input | 1 | Write control, high blocks programming |
| busy_o | output | 1 | Internal write cycle in progress, shared with the sibling port target |

## Verification
Bus lines pass through a two-flop synchronizer and one edge register. Each SCL fall therefore changes sda_oe_o on the third clock after the fall, and the bench holds each SCL half-period for six clocks, so acknowledge and data bits settle before it samples them mid-high. The bench records the clock count at which it raises SDA for STOP. Its behavioural model then expects busy_o high from that count plus three for WR_CYCLES clocks. busy_o is compared with this expectation at every falling clock edge. Read data, acknowledges and the word pointer are predicted from a byte array and an integer pointer in the bench.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WADR,
    S_WAACK,
    S_WDAT,
    S_WDACK,
    S_RDAT,
    S_RACK
  } eep_st_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [1:0] scl_s, sda_s;
  logic       scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_p <= scl_s[1];
      sda_p <= sda_s[1];
    end
  end

  assign scl_rise_o = scl_s[1] & ~scl_p;
  assign scl_fall_o = ~scl_s[1] & scl_p;
  assign start_o    = scl_s[1] & scl_p & sda_p & ~sda_s[1];
  assign stop_o     = scl_s[1] & scl_p & ~sda_p & sda_s[1];
  assign sda_o      = sda_s[1];
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int unsigned WR_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PB = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         commit_i,
  input  logic [AW-PB-1:0]             page_i,
  input  logic [(1<<PB)-1:0]           slot_vld_i,
  input  logic [(1<<PB)-1:0][DW-1:0]   slot_dat_i,
  input  logic [AW-1:0]                raddr_i,
  output logic [DW-1:0]                rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PB;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '{default: '0};
    end else if (commit_i) begin
      for (int i = 0; i < SLOTS; i++)
        if (slot_vld_i[i]) mem_q[{page_i, PB'(i)}] <= slot_dat_i[i];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          PB        = 2,
  parameter int unsigned WR_CYCLES = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wc_ni,
  output logic       busy_o
);
  localparam int DW    = 8;
  localparam int SLOTS = 1 << PB;

  logic scl_rise, scl_fall, start_evt, stop_evt, sda_s;

  eep_st_e                   st_q;
  logic [3:0]                cnt_q;
  logic [DW-1:0]             sh_q, tx_q;
  logic [AW-1:0]             ptr_q;
  logic                      oe_q, mack_q;
  logic [SLOTS-1:0]          slot_vld_q;
  logic [SLOTS-1:0][DW-1:0]  slot_dat_q;
  logic [DW-1:0]             rdata;
  logic                      commit;

  eep_bus_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt),
    .sda_o      (sda_s)
  );

  // only STOP programs the array; WC high drops the buffered page
  assign commit = stop_evt & (|slot_vld_q) & ~wc_ni & ~busy_o;

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit),
    .busy_o (busy_o)
  );

  eep_store #(.AW(AW), .DW(DW), .PB(PB)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .page_i     (ptr_q[AW-1:PB]),
    .slot_vld_i (slot_vld_q),
    .slot_dat_i (slot_dat_q),
    .raddr_i    (ptr_q),
    .rdata_o    (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      mack_q     <= 1'b0;
      slot_vld_q <= '0;
      slot_dat_q <= '0;
    end else if (start_evt) begin
      st_q       <= S_ADDR;
      cnt_q      <= '0;
      oe_q       <= 1'b0;
      slot_vld_q <= '0;
    end else if (stop_evt) begin
      st_q       <= S_IDLE;
      oe_q       <= 1'b0;
      slot_vld_q <= '0;
    end else begin
      unique case (st_q)
        S_ADDR, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[DW-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_q <= '0;
            if (st_q == S_ADDR) begin
              if (sh_q[7:1] == {DEV_ID, strap_i} && !busy_o) begin
                st_q <= S_AACK;
                oe_q <= 1'b1;
              end else begin
                st_q <= S_IDLE;
              end
            end else if (st_q == S_WADR) begin
              st_q <= S_WAACK;
              oe_q <= 1'b1;
            end else begin
              st_q <= S_WDACK;
              oe_q <= 1'b1;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (sh_q[0]) begin
            st_q  <= S_RDAT;
            tx_q  <= rdata;
            ptr_q <= ptr_q + 1'b1;
            oe_q  <= ~rdata[DW-1];
          end else begin
            st_q <= S_WADR;
            oe_q <= 1'b0;
          end
        end
        S_WAACK: if (scl_fall) begin
          ptr_q <= sh_q;
          st_q  <= S_WDAT;
          oe_q  <= 1'b0;
        end
        S_WDACK: if (scl_fall) begin
          slot_dat_q[ptr_q[PB-1:0]] <= sh_q;
          slot_vld_q[ptr_q[PB-1:0]] <= 1'b1;
          ptr_q <= {ptr_q[AW-1:PB], ptr_q[PB-1:0] + 1'b1};
          st_q  <= S_WDAT;
          oe_q  <= 1'b0;
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              st_q  <= S_RACK;
            end else begin
              oe_q <= ~tx_q[DW-2];
              tx_q <= {tx_q[DW-2:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_q  <= S_RDAT;
              tx_q  <= rdata;
              ptr_q <= ptr_q + 1'b1;
              oe_q  <= ~rdata[DW-1];
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 500000
) (
  input logic    clk_i,
  input logic    rst_ni,
  input logic    busy_i,
  input logic    sda_oe_i,
  input logic    wc_ni,
  input eep_st_e st_i
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= 0;
    else if (busy_i) hi_cnt <= hi_cnt + 1;
    else             hi_cnt <= 0;
  end

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> hi_cnt == WR_CYCLES);

  assert_busy_no_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> st_i != S_AACK);

  assert_wc_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(wc_ni));

  assert_idle_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == S_IDLE |-> !sda_oe_i);

  assert_drive_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_i |-> (st_i == S_AACK || st_i == S_WAACK || st_i == S_WDACK || st_i == S_RDAT));
endmodule

bind i2c_eeprom_target eep_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_o),
  .sda_oe_i (sda_oe_o),
  .wc_ni    (wc_ni),
  .st_i     (st_q)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
  localparam int W  = 200;
  localparam int HP = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wc_n = 1'b0;
  logic sda_oe, busy;
  logic sda_line;
  int   cyc = 0, nchk = 0, nerr = 0, bz_start = -1;

  logic [7:0] mdl [256];
  logic [7:0] mptr = 8'h00;
  logic [7:0] pdat [4];
  logic [3:0] pvld = 4'h0;
  logic [7:0] wbuf [8];

  assign sda_line = m_sda & ~sda_oe;

  i2c_eeprom_target #(.WR_CYCLES(W)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .strap_i  (STRAP),
    .wc_ni    (wc_n),
    .busy_o   (busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R6: busy_o compared with the model every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit e;
      e = (bz_start >= 0) && (cyc >= bz_start) && (cyc < bz_start + W);
      chk(busy === e, "R6", busy, e);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b;  wt(HP);
    m_scl = 1'b1; wt(HP/2);
    s = sda_line; wt(HP/2);
    m_scl = 1'b0; wt(2);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(HP);
    m_scl = 1'b1; wt(HP);
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b0; wt(2);
    pvld = 4'h0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b1; wt(HP);
    m_sda = 1'b1;
    if (pvld != 4'h0 && !wc_n) begin
      for (int i = 0; i < 4; i++)
        if (pvld[i]) mdl[{mptr[7:2], 2'(i)}] = pdat[i];
      bz_start = cyc + 3;
    end
    pvld = 4'h0;
    wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(!mack, s);
  endtask

  task automatic addr_phase(input logic [6:0] a, input bit rd, input bit exp, input string req);
    logic k;
    send_byte({a, rd}, k);
    chk(k == exp, req, k, exp);
  endtask

  task automatic write_bytes(input logic [7:0] wa, input int n, input string req);
    logic k;
    bus_start();
    addr_phase({4'b1010, STRAP}, 1'b0, 1'b1, "R1");
    send_byte(wa, k);
    chk(k == 1'b1, "R2", k, 1);
    mptr = wa;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k);
      chk(k == 1'b1, req, k, 1);
      pdat[mptr[1:0]] = wbuf[i];
      pvld[mptr[1:0]] = 1'b1;
      mptr = {mptr[7:2], mptr[1:0] + 2'd1};
    end
    bus_stop();
  endtask

  task automatic read_seq(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      chk(b == mdl[mptr], req, b, mdl[mptr]);
      mptr = mptr + 8'd1;
    end
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    logic k;
    bus_start();
    addr_phase({4'b1010, STRAP}, 1'b0, 1'b1, "R10");
    send_byte(a, k);
    chk(k == 1'b1, "R10", k, 1);
    mptr = a;
    bus_start();
    addr_phase({4'b1010, STRAP}, 1'b1, 1'b1, "R10");
    read_seq(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    wt(4);
    rst_n = 1'b1;
    wt(4);
    chk(busy == 1'b0, "R12", busy, 0);
    chk(sda_oe == 1'b0, "R12", sda_oe, 0);
    rand_read(8'h7C, 3, "R12");

    // R1: wrong strap and wrong prefix are ignored
    bus_start();
    addr_phase({4'b1010, ~STRAP}, 1'b0, 1'b0, "R1");
    bus_stop();
    bus_start();
    addr_phase({4'b1011, STRAP}, 1'b1, 1'b0, "R1");
    bus_stop();

    // R3: byte write then readback
    wbuf[0] = 8'hA5;
    write_bytes(8'h10, 1, "R2");
    // R7: address refused during the write cycle
    bus_start();
    addr_phase({4'b1010, STRAP}, 1'b0, 1'b0, "R7");
    bus_stop();
    wt(W);
    rand_read(8'h10, 1, "R3");

    // R9: current-address read after a random read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_bytes(8'h20, 2, "R2");
    wt(W + 4);
    rand_read(8'h20, 1, "R10");
    bus_start();
    addr_phase({4'b1010, STRAP}, 1'b1, 1'b1, "R9");
    read_seq(1, "R9");
    bus_stop();

    // R4: five bytes from slot 2 of page 0x40
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    wbuf[3] = 8'h04; wbuf[4] = 8'h05;
    wbuf[5] = 8'hEE;
    write_bytes(8'h45, 1, "R2");
    wt(W + 4);
    write_bytes(8'h42, 5, "R4");
    wt(W + 4);
    rand_read(8'h3E, 8, "R4");
    chk(mdl[8'h42] == 8'h05, "R4", mdl[8'h42], 5);

    // R8: write control high
    wc_n = 1'b1;
    wbuf[0] = 8'h77;
    write_bytes(8'h50, 1, "R8");
    wt(W + 4);
    wc_n = 1'b0;
    rand_read(8'h50, 1, "R8");

    // R5: repeated START discards buffered data
    begin
      logic k;
      bus_start();
      addr_phase({4'b1010, STRAP}, 1'b0, 1'b1, "R5");
      send_byte(8'h60, k);
      mptr = 8'h60;
      send_byte(8'h99, k);
      chk(k == 1'b1, "R5", k, 1);
      pdat[0] = 8'h99; pvld[0] = 1'b1; mptr = 8'h61;
      bus_start();
      addr_phase({4'b1010, STRAP}, 1'b1, 1'b1, "R5");
      read_seq(1, "R5");
      bus_stop();
    end
    wt(W + 4);
    rand_read(8'h60, 1, "R5");

    // R11: sequential read across 255 -> 0
    wbuf[0] = 8'h5A;
    write_bytes(8'hFF, 1, "R2");
    wt(W + 4);
    wbuf[0] = 8'hC3;
    write_bytes(8'h00, 1, "R2");
    wt(W + 4);
    rand_read(8'hFE, 4, "R11");
    bus_start();
    addr_phase({4'b1010, STRAP}, 1'b1, 1'b1, "R11");
    read_seq(2, "R11");
    bus_stop();

    wt(20);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule